// File: doc/BRIEF.md
# Vector Unit Control and Status Registers

This block is the small register set that a scalar host uses to steer an attached vector execution unit. A host write port and a combinational read port share one byte-wide address. Two addresses are decoded: a 32-bit control/status word at 0x90 and a 32-bit read-only arithmetic-exception word at 0x91. The status word holds an enable bit, a self-clearing reset command, three sticky fault flags that the host clears by writing one, and a busy bit that comes straight from the execution unit. Fields for memory-fault handling and state save/reload are fixed at zero, because faults are assumed to be handled synchronously.

The execution unit reports three kinds of events with single-cycle pulses: an arithmetic exception, which carries a condition summary and a destination-register mask; an illegal opcode; and a hardware error. Each event sets its own flag and switches the unit off in the same clock. Arithmetic reports are ORed into the exception word, so they build up until the host clears them. If the host writes to the read-only word or to an unmapped address, the write changes nothing and a one-cycle error strobe is raised.

Top module: `vu_csr_block`

## Requirements
- R1: Status bit 0 is the enable. A host write to 0x90 loads it from data bit 0, and it drives `unit_enable`.
- R2: Writing 1 to status bit 1 clears bits 7, 24 and 25 and the whole exception word. In the same write, the enable takes data bit 0. Bit 1 always reads 0.
- R3: Status bits 2 to 6, 8 to 23 and 26 to 30 always read 0, whatever the host writes.
- R4: Status bit 7 is write-one-to-clear. Writing 1 clears the flag and the whole exception word. Writing 0 leaves both unchanged.
- R5: Status bit 24 (hardware error) and bit 25 (illegal opcode) are each write-one-to-clear, independently of each other. Writing 0 leaves them unchanged.
- R6: Status bit 31 reads the current level of `busy_in`. Host writes to bit 31 have no effect.
- R7: An arithmetic report updates the exception word on the next edge. Bits 15:0 are ORed with the summary masked to bits 0, 1, 2, 3 and 5. Bits 31:16 are ORed with the destination mask, where bit 16+n marks register n. The same report sets status bit 7 and clears the enable.
- R8: An illegal-opcode pulse sets status bit 25, and a hardware-error pulse sets status bit 24. Each pulse also clears the enable on the same edge.
- R9: When an event pulse and a host status write fall in the same cycle, the event wins. The flag ends up set and the enable ends up cleared, even if the write would have cleared the flag or set the enable.
- R10: A host write to 0x91 or to any unmapped address leaves both registers unchanged. `acc_err` is high for exactly the cycle after that write. Reads of unmapped addresses return 0.
- R11: After `rst_n` is asserted, both words read 0 except bit 31, which follows `busy_in`, and `acc_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 8 | Register address for both reads and writes |
| bus_wdata | input | 32 | Host write data |
| rd_data | output | 32 | Read data for `bus_addr`, combinational |
| acc_err | output | 1 | One-cycle strobe after a write to a read-only or unmapped address |
| busy_in | input | 1 | Busy level from the execution unit |
| arith_evt | input | 1 | Arithmetic exception report pulse |
| arith_summary | input | 16 | Exception condition summary for the report |
| arith_dest | input | 16 | Destination register mask for the report |
| illop_evt | input | 1 | Illegal opcode pulse |
| hwerr_evt | input | 1 | Hardware error pulse |
| unit_enable | output | 1 | Enable level presented to the execution unit |

## Verification
The hardest case to reach from the ports is a host write and an event pulse landing in the same cycle. This is worst when the write tries to clear the very flag the event sets, or to reset the exception word while a new report arrives. A directed step covers this collision for the hardware-error flag. The random phase then drives host writes and event pulses independently on every cycle, so overlaps of every kind happen many times. Each cycle's expected state comes from a bench model that applies the host write first and the event second.

// File: rtl/vu_csr_pkg.sv
`timescale 1ns/1ps
package vu_csr_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  // Status word field positions (host software decodes these)
  localparam int unsigned POS_EN  = 0;
  localparam int unsigned POS_RST = 1;
  localparam int unsigned POS_AEX = 7;
  localparam int unsigned POS_HWE = 24;
  localparam int unsigned POS_ILL = 25;
  localparam int unsigned POS_BSY = 31;

  // Summary bits an arithmetic report may carry
  localparam logic [HALF_W-1:0] SUMMARY_LEGAL = 16'h002F;

  // Index of each sticky fault flag in the flag array
  localparam int unsigned FLG_AEX = 0;
  localparam int unsigned FLG_HWE = 1;
  localparam int unsigned FLG_ILL = 2;
  localparam int unsigned NUM_FLG = 3;

  typedef struct packed {
    logic en;
    logic rst;
    logic aex_clr;
    logic hwe_clr;
    logic ill_clr;
  } host_cmd_t;

  function automatic host_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    host_cmd_t c;
    c.en      = w[POS_EN];
    c.rst     = w[POS_RST];
    c.aex_clr = w[POS_AEX];
    c.hwe_clr = w[POS_HWE];
    c.ill_clr = w[POS_ILL];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    input logic busy, input logic ill, input logic hwe,
    input logic aex, input logic en);
    logic [WORD_W-1:0] s;
    s          = '0;
    s[POS_EN]  = en;
    s[POS_AEX] = aex;
    s[POS_HWE] = hwe;
    s[POS_ILL] = ill;
    s[POS_BSY] = busy;
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] merge_report(
    input logic [WORD_W-1:0] cur,
    input logic [HALF_W-1:0] summary,
    input logic [HALF_W-1:0] dest);
    return cur | {dest, summary & SUMMARY_LEGAL};
  endfunction

endpackage

// File: rtl/vu_csr_decode.sv
`timescale 1ns/1ps
module vu_csr_decode #(
  parameter int unsigned     ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h90,
  parameter logic [ADDR_W-1:0] EXC_OFF    = 8'h91
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              status_sel,
  output logic              exc_sel,
  output logic              status_wr,
  output logic              bad_wr,
  output logic              acc_err
);

  assign status_sel = (bus_addr == STATUS_OFF);
  assign exc_sel    = (bus_addr == EXC_OFF);
  assign status_wr  = bus_wr && status_sel;
  // The exception word is read-only; every other address is unmapped.
  assign bad_wr     = bus_wr && !status_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= bad_wr;
  end

endmodule

// File: rtl/vu_csr_sticky.sv
`timescale 1ns/1ps
module vu_csr_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);

  // A set from the execution unit wins over a host clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/vu_csr_status.sv
`timescale 1ns/1ps
module vu_csr_status
  import vu_csr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      status_wr,
  input  host_cmd_t cmd,
  input  logic      arith_evt,
  input  logic      illop_evt,
  input  logic      hwerr_evt,
  output logic      en_q,
  output logic      aex_q,
  output logic      hwe_q,
  output logic      ill_q,
  output logic      fault_any
);

  logic [NUM_FLG-1:0] flg_set;
  logic [NUM_FLG-1:0] flg_clr;
  logic [NUM_FLG-1:0] flg_q;
  logic               en_d;

  assign fault_any = arith_evt || illop_evt || hwerr_evt;

  assign flg_set[FLG_AEX] = arith_evt;
  assign flg_set[FLG_HWE] = hwerr_evt;
  assign flg_set[FLG_ILL] = illop_evt;

  assign flg_clr[FLG_AEX] = status_wr && (cmd.rst || cmd.aex_clr);
  assign flg_clr[FLG_HWE] = status_wr && (cmd.rst || cmd.hwe_clr);
  assign flg_clr[FLG_ILL] = status_wr && (cmd.rst || cmd.ill_clr);

  for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
    vu_csr_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flg_clr[i]),
      .set   (flg_set[i]),
      .q     (flg_q[i])
    );
  end

  assign aex_q = flg_q[FLG_AEX];
  assign hwe_q = flg_q[FLG_HWE];
  assign ill_q = flg_q[FLG_ILL];

  always_comb begin
    en_d = en_q;
    if (status_wr) en_d = cmd.en;
    if (fault_any) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

endmodule

// File: rtl/vu_csr_excreg.sv
`timescale 1ns/1ps
module vu_csr_excreg
  import vu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              report,
  input  logic [HALF_W-1:0] summary,
  input  logic [HALF_W-1:0] dest,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] nxt;

  // Host clear applies first; a report in the same cycle survives it.
  assign base = clr ? '0 : q;
  assign nxt  = report ? merge_report(base, summary, dest) : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/vu_csr_block.sv
`timescale 1ns/1ps
module vu_csr_block
  import vu_csr_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h90,
  parameter logic [ADDR_W-1:0] EXC_OFF    = 8'h91
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] rd_data,
  output logic              acc_err,
  input  logic              busy_in,
  input  logic              arith_evt,
  input  logic [HALF_W-1:0] arith_summary,
  input  logic [HALF_W-1:0] arith_dest,
  input  logic              illop_evt,
  input  logic              hwerr_evt,
  output logic              unit_enable
);

  logic              status_sel;
  logic              exc_sel;
  logic              status_wr;
  logic              bad_wr;
  host_cmd_t         cmd;
  logic              en_q;
  logic              aex_q;
  logic              hwe_q;
  logic              ill_q;
  logic              fault_any;
  logic              exc_clr;
  logic [WORD_W-1:0] exc_q;
  logic [WORD_W-1:0] status_word;

  assign cmd = decode_cmd(bus_wdata);

  vu_csr_decode #(
    .ADDR_W     (ADDR_W),
    .STATUS_OFF (STATUS_OFF),
    .EXC_OFF    (EXC_OFF)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .status_sel (status_sel),
    .exc_sel    (exc_sel),
    .status_wr  (status_wr),
    .bad_wr     (bad_wr),
    .acc_err    (acc_err)
  );

  vu_csr_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_wr (status_wr),
    .cmd       (cmd),
    .arith_evt (arith_evt),
    .illop_evt (illop_evt),
    .hwerr_evt (hwerr_evt),
    .en_q      (en_q),
    .aex_q     (aex_q),
    .hwe_q     (hwe_q),
    .ill_q     (ill_q),
    .fault_any (fault_any)
  );

  assign exc_clr = status_wr && (cmd.rst || cmd.aex_clr);

  vu_csr_excreg u_excreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (exc_clr),
    .report  (arith_evt),
    .summary (arith_summary),
    .dest    (arith_dest),
    .q       (exc_q)
  );

  assign status_word = pack_status(busy_in, ill_q, hwe_q, aex_q, en_q);
  assign unit_enable = en_q;

  always_comb begin
    rd_data = '0;
    if (status_sel)   rd_data = status_word;
    else if (exc_sel) rd_data = exc_q;
  end

endmodule

// File: rtl/vu_csr_checker.sv
`timescale 1ns/1ps
module vu_csr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        status_sel,
  input logic        status_wr,
  input logic        bad_wr,
  input logic        acc_err,
  input logic        cmd_en,
  input logic        cmd_rst,
  input logic        exc_clr,
  input logic        fault_any,
  input logic        arith_evt,
  input logic        illop_evt,
  input logic        hwerr_evt,
  input logic        busy_in,
  input logic        unit_enable,
  input logic        aex_q,
  input logic        hwe_q,
  input logic        ill_q,
  input logic [31:0] exc_q,
  input logic [31:0] rd_data
);

  a_r1_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr && !fault_any |=> unit_enable == $past(cmd_en));

  a_r2_reset_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr && cmd_rst && !fault_any |=> exc_q == 32'h0 && !aex_q && !hwe_q && !ill_q);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> (rd_data & 32'h7CFF_FF7E) == 32'h0);

  a_r6_busy_visible: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> rd_data[31] == busy_in);

  a_r7_report_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    arith_evt |=> aex_q && !unit_enable);

  a_r7_report_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
    arith_evt && !exc_clr |=> (exc_q & $past(exc_q)) == $past(exc_q));

  a_r8_fault_disables: assert property (@(posedge clk) disable iff (!rst_n)
    illop_evt || hwerr_evt |=> !unit_enable);

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hwerr_evt && illop_evt |=> hwe_q && ill_q);

  a_r10_err_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> acc_err);

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !acc_err);

  a_r10_exc_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr && !arith_evt |=> $stable(exc_q));

endmodule

bind vu_csr_block vu_csr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_sel  (status_sel),
  .status_wr   (status_wr),
  .bad_wr      (bad_wr),
  .acc_err     (acc_err),
  .cmd_en      (cmd.en),
  .cmd_rst     (cmd.rst),
  .exc_clr     (exc_clr),
  .fault_any   (fault_any),
  .arith_evt   (arith_evt),
  .illop_evt   (illop_evt),
  .hwerr_evt   (hwerr_evt),
  .busy_in     (busy_in),
  .unit_enable (unit_enable),
  .aex_q       (aex_q),
  .hwe_q       (hwe_q),
  .ill_q       (ill_q),
  .exc_q       (exc_q),
  .rd_data     (rd_data)
);

// File: tb/vu_csr_block_tb.sv
`timescale 1ns/1ps
module vu_csr_block_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] rd_data;
  logic        acc_err;
  logic        busy_in = 1'b0;
  logic        arith_evt = 1'b0;
  logic [15:0] arith_summary = 16'h0;
  logic [15:0] arith_dest = 16'h0;
  logic        illop_evt = 1'b0;
  logic        hwerr_evt = 1'b0;
  logic        unit_enable;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench model
  logic        m_en, m_aex, m_hwe, m_ill;
  logic [31:0] m_exc;
  logic        m_err;

  always #10 clk = ~clk;

  vu_csr_block u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .rd_data       (rd_data),
    .acc_err       (acc_err),
    .busy_in       (busy_in),
    .arith_evt     (arith_evt),
    .arith_summary (arith_summary),
    .arith_dest    (arith_dest),
    .illop_evt     (illop_evt),
    .hwerr_evt     (hwerr_evt),
    .unit_enable   (unit_enable)
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] s = 32'h0;
    s[0]  = m_en;
    s[7]  = m_aex;
    s[24] = m_hwe;
    s[25] = m_ill;
    s[31] = busy_in;
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_back(input string tag);
    bus_addr = 8'h90; #1;
    check({tag, " status"}, rd_data, exp_status());
    check({tag, " enable pin"}, {31'h0, unit_enable}, {31'h0, m_en});
    bus_addr = 8'h91; #1;
    check({tag, " exception"}, rd_data, m_exc);
  endtask

  // One clock: drive at negedge, update model (write first, then events), check after edge.
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic ar, input logic [15:0] sm, input logic [15:0] ds,
                      input logic il, input logic hw, input logic bsy, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    arith_evt = ar; arith_summary = sm; arith_dest = ds;
    illop_evt = il; hwerr_evt = hw; busy_in = bsy;
    if (wr && a == 8'h90) begin
      if (d[1] || d[7]) begin m_aex = 1'b0; m_exc = 32'h0; end
      if (d[1] || d[24]) m_hwe = 1'b0;
      if (d[1] || d[25]) m_ill = 1'b0;
      m_en = d[0];
    end
    if (ar) begin
      m_exc = m_exc | {ds, sm & 16'h002F};
      m_aex = 1'b1; m_en = 1'b0;
    end
    if (il) begin m_ill = 1'b1; m_en = 1'b0; end
    if (hw) begin m_hwe = 1'b1; m_en = 1'b0; end
    m_err = wr && (a != 8'h90);
    @(posedge clk); #2;
    bus_wr = 1'b0; arith_evt = 1'b0; illop_evt = 1'b0; hwerr_evt = 1'b0;
    check({tag, " R10 acc_err"}, {31'h0, acc_err}, {31'h0, m_err});
    read_back(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_en = 0; m_aex = 0; m_hwe = 0; m_ill = 0; m_exc = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R11 acc_err in reset", {31'h0, acc_err}, 32'h0);
    read_back("R11 reset");
    @(negedge clk); rst_n = 1'b1;

    // R1, R3: write every bit except reset; only enable survives
    step(1, 8'h90, 32'hFFFF_FFFD, 0, 0, 0, 0, 0, 0, "R1 R3 all-ones");
    // R6: busy visible, write to bit 31 has no effect
    step(1, 8'h90, 32'h0000_0001, 0, 0, 0, 0, 0, 1, "R6 busy high");
    step(1, 8'h90, 32'h8000_0001, 0, 0, 0, 0, 0, 0, "R6 busy write");
    // R7: reports accumulate, illegal summary bits dropped
    step(0, 8'h90, 0, 1, 16'hFFFF, 16'h0003, 0, 0, 0, "R7 first report");
    step(0, 8'h90, 0, 1, 16'h0001, 16'h8000, 0, 0, 0, "R7 second report");
    // R10: read-only and unmapped writes
    step(1, 8'h91, 32'h0, 0, 0, 0, 0, 0, 0, "R10 ro write");
    step(0, 8'h91, 32'h0, 0, 0, 0, 0, 0, 0, "R10 strobe drops");
    step(1, 8'h55, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R10 unmapped write");
    bus_addr = 8'h55; #1;
    check("R10 unmapped read", rd_data, 32'h0);
    // R4: writing 0 to bit 7 keeps flag; writing 1 clears flag and exception word
    step(1, 8'h90, 32'h0000_0001, 0, 0, 0, 0, 0, 0, "R4 write zero");
    step(1, 8'h90, 32'h0000_0080, 0, 0, 0, 0, 0, 0, "R4 write one");
    // R8 then R5
    step(0, 8'h90, 0, 0, 0, 0, 1, 0, 0, "R8 illegal opcode");
    step(1, 8'h90, 32'h1, 0, 0, 0, 0, 1, 0, "R8 hw error beats enable");
    step(1, 8'h90, 32'h0100_0000, 0, 0, 0, 0, 0, 0, "R5 clear hw only");
    step(1, 8'h90, 32'h0200_0000, 0, 0, 0, 0, 0, 0, "R5 clear illegal");
    // R2: reset with enable
    step(0, 8'h90, 0, 1, 16'h0020, 16'h0010, 1, 1, 0, "R2 prep");
    step(1, 8'h90, 32'h0000_0003, 0, 0, 0, 0, 0, 0, "R2 reset and enable");
    // R9: collision of clear and set
    step(1, 8'h90, 32'h0100_0001, 0, 0, 0, 0, 1, 0, "R9 clear vs set");
    step(1, 8'h90, 32'h0000_0002, 1, 16'h0004, 16'h0001, 0, 0, 0, "R9 reset vs report");

    // Random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int unsigned sel = $urandom_range(0, 9);
      a = (sel < 6) ? 8'h90 : (sel < 8) ? 8'h91 : 8'($urandom);
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[1] = 1'b0;
      step($urandom_range(0, 1) == 1, a, d,
           $urandom_range(0, 4) == 0, 16'($urandom), 16'($urandom),
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 1) == 1, "R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule